// File: doc/BRIEF.md
# Power Request Sequencer

A register-mapped slave that takes two kinds of request from software and runs one at a time over a downstream request port. The first kind changes the performance level of one of two clusters. The second kind is a configuration read or write aimed at a function/device pair. Each request's outcome is recorded as a completion flag or an error flag in a status register, grouped by request type. A level-high interrupt stays asserted while any flag is set.

Software writes a level register or the command register to start a request. The block presents the request on a valid/ready port and holds it until the responder accepts it. It then waits for a single-cycle response pulse that carries an error bit and, for configuration reads, a data word. Only one request can be outstanding. A second request that arrives before the first finishes is dropped and marks an error for its own type. Reading the status register returns the flags and clears them.

Top module: `pwr_req_engine`

## Requirements
- R1: After reset, both cluster levels, the status register, the read-data register, `irq` and `dn_valid` are all zero.
- R2: Writing the cluster 0 level register (word address 0x0) or the cluster 1 level register (0x1) while idle raises `dn_valid` after the write edge, with `dn_kind` 0 or 1, `dn_write`=1 and `dn_wdata` holding bits 2:0 of the written value. The request and its payload stay unchanged until a cycle with `dn_ready` high.
- R3: Reading a level register returns the cluster's current level (0 to 7) and starts no request. The level takes the requested value only when that cluster's request completes without error.
- R4: A write to the command register (0x2) with bit 31 set launches a request with `dn_kind`=2. Bit 30 gives `dn_write` (1 write, 0 read), bits 25:20 give `dn_func`, bits 11:0 give `dn_dev`, and `dn_wdata` is the value last written to the write-data register (0x3). A command write with bit 31 clear does nothing.
- R5: When a configuration read completes with `rsp_err`=0, the read-data register (0x4) holds `rsp_rdata`. An erroring or write completion leaves that register unchanged.
- R6: In the status register (0x5), request type t (0 = cluster 0 level, 1 = cluster 1 level, 2 = configuration) sets bit 4t on completion without error and bit 4t+1 on error. All other bits read zero.
- R7: `irq` is high exactly while at least one status flag is set.
- R8: A status read returns the flags as they were before the read and clears them. A flag set in the same cycle as the read survives the read.
- R9: A request that arrives while another is outstanding leaves the downstream port unchanged and sets the error flag of its own type.
- R10: A response pulse while no request is outstanding changes no flag, level or data register.
- R11: Bus read data appears on `bus_rdata` one clock after the cycle with `bus_rd` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, registered |
| irq | output | 1 | Level-high interrupt, any flag set |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted |
| dn_kind | output | 2 | Request type 0, 1 or 2 |
| dn_write | output | 1 | Request is a write |
| dn_func | output | 6 | Configuration function code |
| dn_dev | output | 12 | Configuration device number |
| dn_wdata | output | 32 | Level or configuration write data |
| rsp_valid | input | 1 | Single-cycle response pulse |
| rsp_err | input | 1 | Response reports an error |
| rsp_rdata | input | 32 | Response read data |

## Verification
The assertions check on every cycle that a held request keeps its payload until accepted, that `dn_valid` only appears while a request is outstanding, that flags stay set until a status read, that a read with no new event empties the status, and that unused status bits stay zero. The bench scenarios show the end-to-end effects that span several cycles: a level update after a clean completion and no update after an error, read data captured only on a clean configuration read, rejection of a request made while another is outstanding, and a flag that is set in the same cycle as a status read and survives it.

// File: rtl/pre_pkg.sv
package pre_pkg;
  localparam int NUM_KINDS = 3;
  localparam int LANE_W    = 4;
  localparam int FLAG_W    = NUM_KINDS * LANE_W;

  typedef enum logic [1:0] {
    KIND_LVL0 = 2'd0,
    KIND_LVL1 = 2'd1,
    KIND_CFG  = 2'd2
  } req_kind_e;

  localparam logic [3:0] A_LVL0   = 4'h0;
  localparam logic [3:0] A_LVL1   = 4'h1;
  localparam logic [3:0] A_CMD    = 4'h2;
  localparam logic [3:0] A_WDATA  = 4'h3;
  localparam logic [3:0] A_RDATA  = 4'h4;
  localparam logic [3:0] A_STATUS = 4'h5;

  localparam int CMD_GO_BIT   = 31;
  localparam int CMD_WR_BIT   = 30;
  localparam int CMD_FUNC_LSB = 20;
  localparam int CMD_DEV_LSB  = 0;
endpackage

// File: rtl/pre_req_ctrl.sv
module pre_req_ctrl #(
  parameter int DATA_W = 32,
  parameter int FUNC_W = 6,
  parameter int DEV_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  pre_pkg::req_kind_e start_kind,
  input  logic              start_write,
  input  logic [FUNC_W-1:0] start_func,
  input  logic [DEV_W-1:0]  start_dev,
  input  logic [DATA_W-1:0] start_wdata,
  output logic              dn_valid,
  input  logic              dn_ready,
  output pre_pkg::req_kind_e dn_kind,
  output logic              dn_write,
  output logic [FUNC_W-1:0] dn_func,
  output logic [DEV_W-1:0]  dn_dev,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  output logic              busy,
  output logic              done_v,
  output logic              done_err,
  output logic              rej_v
);
  import pre_pkg::*;

  logic accept;
  assign accept   = start && !busy;
  assign rej_v    = start && busy;
  assign done_v   = rsp_valid && busy && !dn_valid;
  assign done_err = rsp_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      dn_valid <= 1'b0;
      dn_kind  <= KIND_LVL0;
      dn_write <= 1'b0;
      dn_func  <= '0;
      dn_dev   <= '0;
      dn_wdata <= '0;
    end else begin
      if (accept) begin
        busy     <= 1'b1;
        dn_valid <= 1'b1;
        dn_kind  <= start_kind;
        dn_write <= start_write;
        dn_func  <= start_func;
        dn_dev   <= start_dev;
        dn_wdata <= start_wdata;
      end else begin
        if (dn_valid && dn_ready) dn_valid <= 1'b0;
        if (done_v) busy <= 1'b0;
      end
    end
  end

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (rst)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_kind) && $stable(dn_write)
      && $stable(dn_func) && $stable(dn_dev) && $stable(dn_wdata)); // R2
  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (rst)
    dn_valid |-> busy); // R9
  AST_STRAY_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !busy && !start |=> !busy && !dn_valid); // R10
endmodule

// File: rtl/pre_status.sv
module pre_status (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      done_v,
  input  logic                      done_err,
  input  pre_pkg::req_kind_e        done_kind,
  input  logic                      rej_v,
  input  pre_pkg::req_kind_e        rej_kind,
  input  logic                      clr,
  output logic [pre_pkg::FLAG_W-1:0] flags,
  output logic                      irq
);
  import pre_pkg::*;

  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] flags_n;

  for (genvar t = 0; t < NUM_KINDS; t++) begin : g_lane
    logic hit_done, hit_rej;
    assign hit_done = done_v && (done_kind == req_kind_e'(t));
    assign hit_rej  = rej_v && (rej_kind == req_kind_e'(t));
    assign set_vec[t*LANE_W]     = hit_done && !done_err;
    assign set_vec[t*LANE_W + 1] = (hit_done && done_err) || hit_rej;
    assign set_vec[t*LANE_W + LANE_W - 1 : t*LANE_W + 2] = '0;
  end

  assign flags_n = (clr ? '0 : flags) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= flags_n;
      irq   <= |flags_n;
    end
  end

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    clr && !done_v && !rej_v |=> flags == '0 && !irq); // R8
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (flags & $past(flags)) == $past(flags)); // R8
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (flags & 12'hCCC) == '0); // R6
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> irq); // R7
endmodule

// File: rtl/pwr_req_engine.sv
module pwr_req_engine #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int LVL_W  = 3,
  parameter int FUNC_W = 6,
  parameter int DEV_W  = 12,
  parameter int N_CLUS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [1:0]        dn_kind,
  output logic              dn_write,
  output logic [FUNC_W-1:0] dn_func,
  output logic [DEV_W-1:0]  dn_dev,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic [DATA_W-1:0] rsp_rdata
);
  import pre_pkg::*;

  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [LVL_W-1:0]  lvl_q [N_CLUS];
  logic [FLAG_W-1:0] flags;

  // request launch decode
  logic              st_v;
  req_kind_e         st_kind;
  logic              st_write;
  logic [FUNC_W-1:0] st_func;
  logic [DEV_W-1:0]  st_dev;
  logic [DATA_W-1:0] st_wdata;

  always_comb begin
    st_v     = 1'b0;
    st_kind  = KIND_LVL0;
    st_write = 1'b1;
    st_func  = '0;
    st_dev   = '0;
    st_wdata = DATA_W'(bus_wdata[LVL_W-1:0]);
    if (bus_wr) begin
      unique case (bus_addr)
        A_LVL0: st_v = 1'b1;
        A_LVL1: begin
          st_v    = 1'b1;
          st_kind = KIND_LVL1;
        end
        A_CMD: begin
          st_v     = bus_wdata[CMD_GO_BIT];
          st_kind  = KIND_CFG;
          st_write = bus_wdata[CMD_WR_BIT];
          st_func  = bus_wdata[CMD_FUNC_LSB +: FUNC_W];
          st_dev   = bus_wdata[CMD_DEV_LSB +: DEV_W];
          st_wdata = wdata_q;
        end
        default: st_v = 1'b0;
      endcase
    end
  end

  req_kind_e dn_kind_e;
  logic      busy, done_v, done_err, rej_v;

  pre_req_ctrl #(.DATA_W(DATA_W), .FUNC_W(FUNC_W), .DEV_W(DEV_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .start(st_v), .start_kind(st_kind), .start_write(st_write),
    .start_func(st_func), .start_dev(st_dev), .start_wdata(st_wdata),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_kind(dn_kind_e),
    .dn_write(dn_write), .dn_func(dn_func), .dn_dev(dn_dev), .dn_wdata(dn_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .busy(busy), .done_v(done_v), .done_err(done_err), .rej_v(rej_v)
  );
  assign dn_kind = dn_kind_e;

  logic st_clr;
  assign st_clr = bus_rd && (bus_addr == A_STATUS);

  pre_status u_stat (
    .clk(clk), .rst(rst),
    .done_v(done_v), .done_err(done_err), .done_kind(dn_kind_e),
    .rej_v(rej_v), .rej_kind(st_kind),
    .clr(st_clr), .flags(flags), .irq(irq)
  );

  // per-cluster current level
  for (genvar c = 0; c < N_CLUS; c++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (rst) lvl_q[c] <= '0;
      else if (done_v && !done_err && dn_kind_e == req_kind_e'(c))
        lvl_q[c] <= dn_wdata[LVL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (bus_wr && bus_addr == A_WDATA) wdata_q <= bus_wdata;
      if (done_v && !done_err && dn_kind_e == KIND_CFG && !dn_write)
        rdata_q <= rsp_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      unique case (bus_addr)
        A_LVL0:   bus_rdata <= DATA_W'(lvl_q[0]);
        A_LVL1:   bus_rdata <= DATA_W'(lvl_q[1]);
        A_WDATA:  bus_rdata <= wdata_q;
        A_RDATA:  bus_rdata <= rdata_q;
        A_STATUS: bus_rdata <= DATA_W'(flags);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  AST_LVL_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    !done_v |=> lvl_q[0] == $past(lvl_q[0]) && lvl_q[1] == $past(lvl_q[1])); // R3
  AST_RDATA_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    !done_v |=> $stable(rdata_q)); // R5
endmodule

// File: tb/pwr_req_engine_test.sv
`timescale 1ns/1ps
module pwr_req_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        irq, dn_valid, dn_write;
  logic        dn_ready = 0;
  logic [1:0]  dn_kind;
  logic [5:0]  dn_func;
  logic [11:0] dn_dev;
  logic [31:0] dn_wdata;
  logic        rsp_valid = 0, rsp_err = 0;
  logic [31:0] rsp_rdata = 0;

  int checks = 0;
  int errors = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  pwr_req_engine uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_kind(dn_kind), .dn_write(dn_write),
    .dn_func(dn_func), .dn_dev(dn_dev), .dn_wdata(dn_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rdreg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic accept_req(input int delay);
    while (!dn_valid) @(negedge clk);
    for (int i = 0; i < delay; i++) @(negedge clk);
    dn_ready = 1;
    @(negedge clk);
    dn_ready = 0;
  endtask

  task automatic respond(input logic err, input logic [31:0] d);
    @(negedge clk);
    rsp_valid = 1; rsp_err = err; rsp_rdata = d;
    @(negedge clk);
    rsp_valid = 0; rsp_err = 0;
  endtask

  task automatic t_reset();
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 dn_valid", {31'b0, dn_valid}, 0);
    rdreg(4'h5, rd); chk("R1 status", rd, 0);
    rdreg(4'h0, rd); chk("R1 level0", rd, 0);
    rdreg(4'h1, rd); chk("R1 level1", rd, 0);
    rdreg(4'h4, rd); chk("R1 rdata", rd, 0);
  endtask

  task automatic t_perf_ok();
    wr(4'h1, 32'hFFFF_FFFD);
    chk("R2 valid", {31'b0, dn_valid}, 1);
    chk("R2 kind", {30'b0, dn_kind}, 1);
    chk("R2 write", {31'b0, dn_write}, 1);
    chk("R2 level data", dn_wdata, 5);
    rdreg(4'h1, rd); chk("R3 level before done", rd, 0);
    accept_req(0);
    chk("R2 released", {31'b0, dn_valid}, 0);
    respond(0, 0);
    chk("R7 irq set", {31'b0, irq}, 1);
    rdreg(4'h1, rd); chk("R3 level after done", rd, 5);
    rdreg(4'h5, rd); chk("R6 lane1 done", rd, 32'h10);
    chk("R7 irq cleared", {31'b0, irq}, 0);
    rdreg(4'h5, rd); chk("R8 cleared", rd, 0);
  endtask

  task automatic t_perf_err();
    wr(4'h0, 3);
    chk("R2 kind0", {30'b0, dn_kind}, 0);
    accept_req(1);
    respond(1, 0);
    rdreg(4'h5, rd); chk("R6 lane0 error", rd, 32'h2);
    rdreg(4'h0, rd); chk("R3 level kept on error", rd, 0);
  endtask

  task automatic t_cfg_write();
    wr(4'h3, 32'hCAFE_1234);
    wr(4'h2, 32'hC000_0000 | (32'd6 << 20) | 32'h30C);
    chk("R4 kind", {30'b0, dn_kind}, 2);
    chk("R4 write", {31'b0, dn_write}, 1);
    chk("R4 func", {26'b0, dn_func}, 6);
    chk("R4 dev", {20'b0, dn_dev}, 32'h30C);
    @(negedge clk); @(negedge clk);
    chk("R2 held", {31'b0, dn_valid}, 1);
    chk("R4 wdata", dn_wdata, 32'hCAFE_1234);
    accept_req(0);
    respond(0, 32'h7777_7777);
    rdreg(4'h5, rd); chk("R6 lane2 done", rd, 32'h100);
    rdreg(4'h4, rd); chk("R5 write no capture", rd, 0);
  endtask

  task automatic t_cfg_read();
    wr(4'h2, 32'h8000_0000 | (32'h2A << 20) | 32'hABC);
    chk("R4 read dir", {31'b0, dn_write}, 0);
    chk("R4 func read", {26'b0, dn_func}, 32'h2A);
    chk("R4 dev read", {20'b0, dn_dev}, 32'hABC);
    accept_req(0);
    respond(0, 32'h5A5A_0F0F);
    rdreg(4'h5, rd); chk("R6 read done", rd, 32'h100);
    rdreg(4'h4, rd); chk("R5 capture", rd, 32'h5A5A_0F0F);
    wr(4'h2, 32'h8000_0001);
    accept_req(0);
    respond(1, 32'h1111_1111);
    rdreg(4'h5, rd); chk("R6 read error", rd, 32'h200);
    rdreg(4'h4, rd); chk("R5 kept on error", rd, 32'h5A5A_0F0F);
  endtask

  task automatic t_nostart();
    wr(4'h2, 32'h4000_0123);
    @(negedge clk);
    chk("R4 no start bit", {31'b0, dn_valid}, 0);
    rdreg(4'h5, rd); chk("R4 no flags", rd, 0);
  endtask

  task automatic t_busy();
    wr(4'h0, 6);
    wr(4'h2, 32'hC000_0055);
    chk("R9 still valid", {31'b0, dn_valid}, 1);
    chk("R9 kind kept", {30'b0, dn_kind}, 0);
    chk("R9 data kept", dn_wdata, 6);
    chk("R9 irq on reject", {31'b0, irq}, 1);
    wr(4'h1, 2);
    accept_req(0);
    respond(0, 0);
    rdreg(4'h5, rd); chk("R9 reject flags", rd, 32'h221);
    rdreg(4'h0, rd); chk("R9 level0", rd, 6);
    rdreg(4'h1, rd); chk("R9 level1 unchanged", rd, 5);
  endtask

  task automatic t_idle_rsp();
    respond(0, 32'hDEAD_BEEF);
    chk("R10 irq", {31'b0, irq}, 0);
    rdreg(4'h5, rd); chk("R10 status", rd, 0);
    rdreg(4'h4, rd); chk("R10 rdata", rd, 32'h5A5A_0F0F);
    rdreg(4'h0, rd); chk("R10 level", rd, 6);
  endtask

  task automatic t_clear_race();
    wr(4'h0, 2);
    accept_req(0);
    @(negedge clk);
    rsp_valid = 1; rsp_err = 0;
    bus_rd = 1; bus_addr = 4'h5;
    @(negedge clk);
    rsp_valid = 0; bus_rd = 0;
    chk("R11 R8 old flags", bus_rdata, 0);
    chk("R8 irq after race", {31'b0, irq}, 1);
    rdreg(4'h5, rd); chk("R8 survived", rd, 32'h1);
    rdreg(4'h0, rd); chk("R3 level2", rd, 2);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_perf_ok();
    t_perf_err();
    t_cfg_write();
    t_cfg_read();
    t_nostart();
    t_busy();
    t_idle_rsp();
    t_clear_race();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule